// File: doc/BRIEF.md
# Static-Memory Bus Turnaround Sequencer

This block turns single requests from an internal port into accesses on an external static-memory bus. The bus has a 24-bit address, an 8-bit data path, four active-low device selects and active-low read and write strobes. Each accepted request becomes a fixed three-cycle window: a setup cycle, a strobe cycle and a hold cycle. The device select stays asserted for the whole window. The read or write strobe is asserted only in the middle cycle.

Before a new access starts, the block decides whether the bus needs a turnaround cycle. If the target device differs from the previous access, it inserts one idle cycle in which every select and strobe is high. If a read follows a write on the same device, it inserts one early-read wait cycle. The two idle cycles never stack. Every other pairing runs back to back. The memory of the previous access survives any number of cycles without requests and is cleared only by reset.

Requests use a valid/ready handshake. A request can be accepted in the hold cycle of the running access, so accesses can follow each other with no dead cycle. A one-cycle done pulse marks the end of each access and carries the read data.

Top module: `ext_bus_turnaround`

## Requirements
- R1: Each access drives its device select low (select n is bit n of `bus_cs_n`) for exactly three consecutive cycles. The strobe for its direction (`bus_rd_n` for a read, `bus_wr_n` for a write) is low only in the second of those cycles, and the other strobe stays high.
- R2: When an accepted request targets a different device than the previous access, exactly one cycle is inserted before its setup cycle. In that cycle all four selects and both strobes are high, and `req_ready` is low. This holds for any combination of directions.
- R3: When a read request (`req_write`=0) follows a write (`req_write`=1) on the same device, exactly one idle cycle is inserted before its setup cycle, with all control lines high.
- R4: A write followed by a read on a different device gets only the single device-change cycle, never two idle cycles.
- R5: On the same device, read→read, read→write and write→write pairings start the setup cycle in the cycle right after acceptance, with no idle cycle.
- R6: `req_ready` is high when the block is idle and during the hold cycle of an access, and low in idle-insertion, setup and strobe cycles. A request is taken at a clock edge where `req_valid` and `req_ready` are both high.
- R7: `rsp_done` is high for exactly the one cycle that follows each hold cycle. After a read, `rsp_rdata` then equals `bus_rdata` as sampled at the end of that read's strobe cycle.
- R8: `bus_wdata_oe` is high only during the three-cycle window of a write, and low in every idle cycle and every read window.
- R9: During and right after reset, all selects and strobes are high, `bus_wdata_oe` and `rsp_done` are low, and `req_ready` is high. The first access after reset has no idle cycle, whatever its device and direction.
- R10: Cycles with no request do not clear the record of the previous access. A read after a write to the same device still gets the early-read cycle, however long the gap between them.
- R11: `bus_addr` and `bus_wdata` show the accepted request's address and write data throughout its access window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Target device number (0..3) |
| req_addr | input | 24 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` after a read |
| bus_addr | output | 24 | External address bus |
| bus_wdata | output | 8 | External write data |
| bus_wdata_oe | output | 1 | Write data output enable |
| bus_rdata | input | 8 | External read data |
| bus_cs_n | output | 4 | Active-low device selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
Two functions can fall in the same cycle: the done pulse of one access, with its read data, and the first cycle of the next access, which is either an inserted idle cycle or a setup cycle. The stimulus table keeps `req_valid` high into every hold cycle, so each following request is accepted at the hold edge. The bench checks the previous access's done pulse and read data in the same sampling slot where it checks the pins of the new access's idle or setup cycle. The ordered table also covers every pairing of direction and device change, so the idle-cycle decision is judged against its expected kind in each case.

// File: rtl/xbt_pkg.sv
package xbt_pkg;

    // Sequencer phase; both kinds of inserted idle cycle share PH_GAP
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_GAP    = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    // Kind of turnaround chosen for a newly accepted request
    typedef enum logic [1:0] {
        TA_NONE  = 2'd0,
        TA_DEV   = 2'd1,
        TA_EARLY = 2'd2
    } turn_e;

endpackage

// File: rtl/xbt_turn_decider.sv
module xbt_turn_decider
    import xbt_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  logic            prev_vld_i,
    input  logic [CS_W-1:0] prev_cs_i,
    input  logic            prev_wr_i,
    input  logic [CS_W-1:0] next_cs_i,
    input  logic            next_wr_i,
    output turn_e           turn_o
);

    logic dev_change;
    logic wr_to_rd;

    assign dev_change = prev_vld_i && (prev_cs_i != next_cs_i);
    assign wr_to_rd   = prev_vld_i && prev_wr_i && !next_wr_i;

    // A device change wins: the early-read cycle is never added on top
    always_comb begin
        if (dev_change) begin
            turn_o = TA_DEV;
        end else if (wr_to_rd) begin
            turn_o = TA_EARLY;
        end else begin
            turn_o = TA_NONE;
        end
    end

endmodule

// File: rtl/xbt_pin_drive.sv
module xbt_pin_drive
    import xbt_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int CS_W = 2
) (
    input  phase_e          phase_i,
    input  logic [CS_W-1:0] cs_i,
    input  logic            wr_i,
    output logic [NCS-1:0]  cs_n_o,
    output logic            rd_n_o,
    output logic            wr_n_o,
    output logic            oe_o
);

    logic in_window;
    logic in_strobe;

    assign in_window = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) ||
                       (phase_i == PH_HOLD);
    assign in_strobe = (phase_i == PH_STROBE);

    for (genvar g = 0; g < NCS; g++) begin : g_sel
        assign cs_n_o[g] = !(in_window && (cs_i == CS_W'(g)));
    end

    assign rd_n_o = !(in_strobe && !wr_i);
    assign wr_n_o = !(in_strobe && wr_i);
    assign oe_o   = in_window && wr_i;

endmodule

// File: rtl/ext_bus_turnaround.sv
module ext_bus_turnaround
    import xbt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int NCS    = 4,
    localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [NCS-1:0]    bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);

    // last_* describe the most recently accepted access: while it runs it is
    // the current access, once it ends it is the history for the next one
    typedef struct packed {
        phase_e            phase;
        logic              last_vld;
        logic [CS_W-1:0]   last_cs;
        logic              last_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t  st_q, st_d;
    turn_e turn;
    logic  accept;

    xbt_turn_decider #(.CS_W(CS_W)) u_decide (
        .prev_vld_i (st_q.last_vld),
        .prev_cs_i  (st_q.last_cs),
        .prev_wr_i  (st_q.last_wr),
        .next_cs_i  (req_cs),
        .next_wr_i  (req_write),
        .turn_o     (turn)
    );

    assign req_ready = (st_q.phase == PH_IDLE) || (st_q.phase == PH_HOLD);
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d      = st_q;
        st_d.done = (st_q.phase == PH_HOLD);
        unique case (st_q.phase)
            PH_IDLE, PH_HOLD: begin
                if (accept) begin
                    st_d.phase    = (turn == TA_NONE) ? PH_SETUP : PH_GAP;
                    st_d.last_vld = 1'b1;
                    st_d.last_cs  = req_cs;
                    st_d.last_wr  = req_write;
                    st_d.addr     = req_addr;
                    st_d.wdata    = req_wdata;
                end else begin
                    st_d.phase = PH_IDLE;
                end
            end
            PH_GAP:   st_d.phase = PH_SETUP;
            PH_SETUP: st_d.phase = PH_STROBE;
            PH_STROBE: begin
                st_d.phase = PH_HOLD;
                if (!st_q.last_wr) begin
                    st_d.rdata = bus_rdata;
                end
            end
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, last_vld: 1'b0, last_cs: '0, last_wr: 1'b0,
                      addr: '0, wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    xbt_pin_drive #(.NCS(NCS), .CS_W(CS_W)) u_pins (
        .phase_i (st_q.phase),
        .cs_i    (st_q.last_cs),
        .wr_i    (st_q.last_wr),
        .cs_n_o  (bus_cs_n),
        .rd_n_o  (bus_rd_n),
        .wr_n_o  (bus_wr_n),
        .oe_o    (bus_wdata_oe)
    );

    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;
    assign rsp_done  = st_q.done;
    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/xbt_checker.sv
module xbt_checker #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           rsp_done,
    input logic [NCS-1:0] bus_cs_n,
    input logic           bus_rd_n,
    input logic           bus_wr_n,
    input logic           bus_wdata_oe
);

    // R1
    one_sel_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> ($countones(~bus_cs_n) == 1));

    // R1
    rd_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |=> bus_rd_n);

    // R1
    wr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |=> bus_wr_n);

    // R1
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n || bus_wr_n);

    // R2
    sel_switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cs_n != {NCS{1'b1}}) && ($past(bus_cs_n) != {NCS{1'b1}}))
            |-> (bus_cs_n == $past(bus_cs_n)));

    // R6
    ready_not_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_rd_n && bus_wr_n));

    // R7
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_oe |-> ((bus_cs_n != {NCS{1'b1}}) && bus_rd_n));

endmodule

bind ext_bus_turnaround xbt_checker #(.NCS(NCS)) u_xbt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_done     (rsp_done),
    .bus_cs_n     (bus_cs_n),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_wdata_oe (bus_wdata_oe)
);

// File: tb/tb_ext_bus_turnaround.sv
`timescale 1ns/1ps
module tb_ext_bus_turnaround;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = 2'd0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wdata_oe;
    logic [7:0]  bus_rdata;
    logic [3:0]  bus_cs_n;
    logic        bus_rd_n;
    logic        bus_wr_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // simple memory model: read data follows the driven address
    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    ext_bus_turnaround dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    // {write, cs, gap kind (0 none, 1 device change, 2 early read), addr, wdata}
    localparam int NV = 10;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 2'd0, 2'd0, 24'h000010, 8'h11},   // R9 first access
        {1'b1, 2'd0, 2'd0, 24'h000011, 8'h22},   // R5 write-write
        {1'b0, 2'd0, 2'd2, 24'h000012, 8'h00},   // R3 write-read
        {1'b0, 2'd0, 2'd0, 24'h000013, 8'h00},   // R5 read-read
        {1'b1, 2'd0, 2'd0, 24'h000014, 8'h33},   // R5 read-write
        {1'b0, 2'd1, 2'd1, 24'h120015, 8'h00},   // R4 write-read new device
        {1'b1, 2'd2, 2'd1, 24'h340016, 8'h44},   // R2 read-write new device
        {1'b0, 2'd2, 2'd2, 24'h340017, 8'h00},   // R3
        {1'b1, 2'd3, 2'd1, 24'hABCDEF, 8'h55},   // R2
        {1'b1, 2'd1, 2'd1, 24'hFFFFFF, 8'hAA}    // R2 write-write new device
    };

    bit         prev_pend = 1'b0;
    bit         prev_wr = 1'b0;
    logic [23:0] prev_addr = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // pins packed as {cs_n, rd_n, wr_n, oe, ready}
    task automatic pins(input string req, input logic [3:0] cs_n, input bit rd_n,
                        input bit wr_n, input bit oe, input bit rdy);
        logic [7:0] act, exp;
        act = {bus_cs_n, bus_rd_n, bus_wr_n, bus_wdata_oe, req_ready};
        exp = {cs_n, rd_n, wr_n, oe, rdy};
        check(act == exp, req, {24'd0, act}, {24'd0, exp});
    endtask

    // caller is at a negedge with req_ready high; returns at the hold-cycle negedge
    task automatic access(input bit wr, input logic [1:0] cs, input logic [23:0] addr,
                          input logic [7:0] wd, input int gap);
        logic [3:0] sel;
        sel = ~(4'b0001 << cs);
        check(req_ready == 1'b1, "R6 ready before accept", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_cs = cs; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (prev_pend) begin
            // previous access's done pulse shares this cycle with the new access
            check(rsp_done == 1'b1, "R7 done with next access", {31'd0, rsp_done}, 32'd1);
            if (!prev_wr)
                check(rsp_rdata == (prev_addr[7:0] ^ 8'hA5), "R7 read data",
                      {24'd0, rsp_rdata}, {24'd0, prev_addr[7:0] ^ 8'hA5});
        end
        if (gap == 1) begin
            pins("R2/R4 device-change idle", 4'hF, 1'b1, 1'b1, 1'b0, 1'b0);
            @(negedge clk);
        end else if (gap == 2) begin
            pins("R3 early-read idle", 4'hF, 1'b1, 1'b1, 1'b0, 1'b0);
            @(negedge clk);
        end
        pins(gap == 0 ? "R5 setup without idle" : "R1 setup", sel, 1'b1, 1'b1, wr, 1'b0);
        @(negedge clk);
        pins("R1/R8 strobe", sel, wr, !wr, wr, 1'b0);
        check({bus_addr, bus_wdata} == {addr, wd}, "R11 addr/data",
              {bus_addr, bus_wdata}, {addr, wd});
        @(negedge clk);
        pins("R1/R6 hold", sel, 1'b1, 1'b1, wr, 1'b1);
        check(bus_addr == addr, "R11 addr in hold", {8'd0, bus_addr}, {8'd0, addr});
        prev_pend = 1'b1; prev_wr = wr; prev_addr = addr;
    endtask

    // one cycle after a hold with no new request: done pulse, then low
    task automatic finish_idle();
        @(negedge clk);
        check(rsp_done == 1'b1, "R7 done after hold", {31'd0, rsp_done}, 32'd1);
        if (!prev_wr)
            check(rsp_rdata == (prev_addr[7:0] ^ 8'hA5), "R7 read data idle",
                  {24'd0, rsp_rdata}, {24'd0, prev_addr[7:0] ^ 8'hA5});
        pins("R8 idle lines", 4'hF, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(rsp_done == 1'b0, "R7 done single cycle", {31'd0, rsp_done}, 32'd0);
        prev_pend = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (2) @(negedge clk);
        pins("R9 in reset", 4'hF, 1'b1, 1'b1, 1'b0, 1'b1);
        check(rsp_done == 1'b0, "R9 done in reset", {31'd0, rsp_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        pins("R9 after reset", 4'hF, 1'b1, 1'b1, 1'b0, 1'b1);

        // table walk: every request accepted in the previous hold cycle
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][36], VEC[i][35:34], VEC[i][31:8], VEC[i][7:0],
                   int'(VEC[i][33:32]));
        end
        finish_idle();

        // R10: write then long quiet period, then read same device
        access(1'b1, 2'd3, 24'h000100, 8'h5C, 1);
        finish_idle();
        repeat (7) @(negedge clk);
        pins("R10 quiet bus", 4'hF, 1'b1, 1'b1, 1'b0, 1'b1);
        access(1'b0, 2'd3, 24'h000101, 8'h00, 2);   // R10 early read still inserted
        finish_idle();

        // R9: reset clears history, first access on a new device has no idle
        rst_n = 1'b0;
        @(negedge clk);
        pins("R9 reset again", 4'hF, 1'b1, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 2'd2, 24'h000222, 8'h00, 0);   // R9 no idle after reset
        finish_idle();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule